// File: doc/BRIEF.md
# 16-bit Compare-Clear Timer Channel

This block is one up-counting 16-bit timer channel. It has two compare registers and a control byte that sets three things: the count clock, the count instant inside the divided period, and what clears the counter. The count clock comes either from the core clock through a divider of 1, 2, 4 or 8, or from one of four external clock pins. The counter can run free through 0xFFFF, it can be held to a period set by either compare register, or it can be cleared by an external sync pin.

The block sets three event flags: compare A, compare B and overflow. Software sees the flags in a status byte and clears a flag by writing 0 to its bit. An enable byte gates each flag onto its own level interrupt request output. Every register is reached through a single-cycle synchronous register bus. Reads come back combinationally on the selected address.

Top module: `tmr16_channel`

## Requirements
- R1: After reset the counter reads 0x0000, both compare registers read 0xFFFF, the control byte reads 0x00, the status and enable bytes read 0xF8, and all three interrupt outputs are low.
- R2: Control bits [2:0] = 0, 1, 2, 3 count the core clock divided by 1, 2, 4 or 8. The divider restarts while `en_i` is low, so with phase 0 the first increment lands on the Nth enabled clock edge. Sixteen enabled edges give 16, 8, 4 or 2 counts.
- R3: For divide-by-4 and divide-by-8, control bits [4:3] = 01 move the count instant half a divided period earlier (the first increment comes on edge N/2), and [4:3] = 1x count on both halves, which halves the divider. For divide-by-1 and divide-by-2 these bits have no effect.
- R4: Control bits [2:0] = 4..7 select external clock pins 0..3. Each pin passes through a two-flop synchronizer and a rising-edge detector. The counter advances once per rising edge of the selected pin, and the other pins are ignored.
- R5: Control bits [6:5] = 01 (compare A) or 10 (compare B), with that compare register nonzero, make the counter run from 0 to value-1 and then return to 0, setting that compare flag as it returns. If the selected register is 0, the counter runs free.
- R6: Control bits [6:5] = 11 clear the counter to 0 on a synchronized rising edge of `sync_clr_i`, even while counting is disabled. In any other clear mode that pin has no effect.
- R7: While `en_i` is low the counter does not advance. A bus write to the counter in the same cycle as an increment loads the written value unchanged.
- R8: The compare A and compare B flags set when the counter reaches the matching register. The overflow flag sets when the counter steps from 0xFFFF to 0x0000.
- R9: Status byte: bit0 is compare A, bit1 is compare B, bit2 is overflow, and bits [7:3] read 1. Writing 0 to a flag bit clears it, and writing 1 leaves it as it was.
- R10: Enable byte: bit0 enables compare A, bit1 compare B, bit2 overflow, and bits [7:3] read 1. Each interrupt output is high exactly while its flag and its enable bit are both set.
- R11: Address map: 0 control, 1 enable, 2 status, 3 counter, 4 compare A, 5 compare B. Addresses 6 and 7 read 0. The control byte reads back all 8 written bits, and 8-bit registers take `wdata_i[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel count enable |
| ext_clk_i | input | 4 | External clock pins 0..3 |
| sync_clr_i | input | 1 | External counter clear pin |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Register write strobe |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data |
| irq_cmp_a_o | output | 1 | Compare A interrupt request |
| irq_cmp_b_o | output | 1 | Compare B interrupt request |
| irq_ovf_o | output | 1 | Overflow interrupt request |

## Verification
The assertions check on every cycle that the counter steps by exactly one in free-running mode and holds while disabled, that a counter write wins over an increment, that the compare-A period bound is kept once the counter is below it, that a wrap from 0xFFFF sets the overflow flag, and that the status byte reads its fixed upper bits. Other behaviours can only be shown by the directed scenarios, because each depends on a particular sequence of stimulus. These are the divider rates and half-period offsets counted from the enable edge, the selection of one external pin among four, clearing from compare B and from the sync pin, write-zero-to-clear on the flags, and the gating of each interrupt by its enable bit.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 3;
  localparam int N_EXT  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_IEN  = 3'd1,
    A_STAT = 3'd2,
    A_CNT  = 3'd3,
    A_CMPA = 3'd4,
    A_CMPB = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_CMPA = 2'b01,
    CLR_CMPB = 2'b10,
    CLR_SYNC = 2'b11
  } clr_mode_e;

  typedef struct packed {
    logic ovf;
    logic cmp_b;
    logic cmp_a;
  } flags_t;
endpackage

// File: rtl/tmr16_edge_det.sv
module tmr16_edge_det #(
  parameter int N    = 5,
  parameter int SYNC = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] rise_o
);
  localparam int SH_W = SYNC + 1;

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [SH_W-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[SH_W-2:0], in_i[g]};
    end
    assign rise_o[g] = sh_q[SH_W-2] & ~sh_q[SH_W-1];
  end
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic [1:0]       edge_sel_i,
  output logic             tick_o
);
  localparam int P_W = (1 << DIV_W) - 1;

  logic [P_W-1:0] p_q;
  logic [P_W-1:0] mask, target;
  int             k;
  logic           half;

  // prescaler restarts while disabled so the count phase is tied to enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    p_q <= '0;
    else if (!en_i) p_q <= '0;
    else            p_q <= p_q + 1'b1;
  end

  always_comb begin
    k    = int'(div_sel_i);
    half = 1'b0;
    if (k >= 2) begin
      if (edge_sel_i[1])           k = k - 1;
      else if (edge_sel_i == 2'b01) half = 1'b1;
    end
    mask   = P_W'((32'd1 << k) - 32'd1);
    target = half ? P_W'((32'd1 << (k - 1)) - 32'd1) : mask;
  end

  assign tick_o = en_i && ((p_q & mask) == target);
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         clr_i,
  input  logic         per_en_i,
  input  logic [W-1:0] per_val_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic [W-1:0] cmp_b_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_a_o,
  output logic         hit_b_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, new_val;
  logic [W:0]   nxt;
  logic         step, cleared;

  assign nxt     = {1'b0, cnt_q} + 1'b1;
  assign cleared = per_en_i && (per_val_i != '0) && (nxt[W-1:0] == per_val_i);
  assign new_val = cleared ? '0 : nxt[W-1:0];
  assign step    = tick_i && !ld_i && !clr_i;

  // a match is seen on the reached value even when the period folds it to 0
  assign hit_a_o = step && ((nxt[W-1:0] == cmp_a_i) || (new_val == cmp_a_i));
  assign hit_b_o = step && ((nxt[W-1:0] == cmp_b_i) || (new_val == cmp_b_i));
  assign wrap_o  = step && nxt[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (clr_i) cnt_q <= '0;
    else if (step)  cnt_q <= new_val;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr16_channel.sv
module tmr16_channel
  import tmr16_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [N_EXT-1:0]  ext_clk_i,
  input  logic              sync_clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_cmp_a_o,
  output logic              irq_cmp_b_o,
  output logic              irq_ovf_o
);
  localparam int N_LANE = N_EXT + 1;

  logic [7:0]       ctrl_q;
  logic [2:0]       ien_q;
  flags_t           flags_q, flags_n;
  logic [CNT_W-1:0] cmp_a_q, cmp_b_q, cnt_q, per_val;
  logic [N_LANE-1:0] rise;
  logic             int_tick, tick, ld, sclr, per_en;
  logic             hit_a, hit_b, wrap;
  clr_mode_e        clr_mode;

  assign clr_mode = clr_mode_e'(ctrl_q[6:5]);
  assign ld       = we_i && (addr_i == A_CNT);

  tmr16_edge_det #(.N(N_LANE), .SYNC(2)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({sync_clr_i, ext_clk_i}),
    .rise_o(rise)
  );

  tmr16_prescale #(.DIV_W(2)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .div_sel_i (ctrl_q[1:0]),
    .edge_sel_i(ctrl_q[4:3]),
    .tick_o    (int_tick)
  );

  assign tick    = ctrl_q[2] ? (en_i && rise[ctrl_q[1:0]]) : int_tick;
  assign sclr    = (clr_mode == CLR_SYNC) && rise[N_EXT];
  assign per_en  = (clr_mode == CLR_CMPA) || (clr_mode == CLR_CMPB);
  assign per_val = (clr_mode == CLR_CMPB) ? cmp_b_q : cmp_a_q;

  tmr16_counter #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .ld_i     (ld),
    .ld_val_i (wdata_i),
    .clr_i    (sclr),
    .per_en_i (per_en),
    .per_val_i(per_val),
    .cmp_a_i  (cmp_a_q),
    .cmp_b_i  (cmp_b_q),
    .cnt_o    (cnt_q),
    .hit_a_o  (hit_a),
    .hit_b_o  (hit_b),
    .wrap_o   (wrap)
  );

  always_comb begin
    flags_n = flags_q;
    if (we_i && addr_i == A_STAT) flags_n = flags_n & flags_t'(wdata_i[2:0]);
    // a new event wins over a same-cycle clear
    flags_n.cmp_a = flags_n.cmp_a | hit_a;
    flags_n.cmp_b = flags_n.cmp_b | hit_b;
    flags_n.ovf   = flags_n.ovf   | wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      ien_q   <= '0;
      flags_q <= '0;
      cmp_a_q <= '1;
      cmp_b_q <= '1;
    end else begin
      flags_q <= flags_n;
      if (we_i) begin
        unique case (addr_i)
          A_CTRL:  ctrl_q  <= wdata_i[7:0];
          A_IEN:   ien_q   <= wdata_i[2:0];
          A_CMPA:  cmp_a_q <= wdata_i;
          A_CMPB:  cmp_b_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {8'h00, ctrl_q};
      A_IEN:   rdata_o = {8'h00, 5'h1f, ien_q};
      A_STAT:  rdata_o = {8'h00, 5'h1f, flags_q};
      A_CNT:   rdata_o = cnt_q;
      A_CMPA:  rdata_o = cmp_a_q;
      A_CMPB:  rdata_o = cmp_b_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_cmp_a_o = flags_q.cmp_a & ien_q[0];
  assign irq_cmp_b_o = flags_q.cmp_b & ien_q[1];
  assign irq_ovf_o   = flags_q.ovf   & ien_q[2];
endmodule

// File: rtl/tmr16_channel_chk.sv
module tmr16_channel_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        we_i,
  input logic [2:0]  addr_i,
  input logic [15:0] wdata_i,
  input logic [15:0] rdata_o,
  input logic [15:0] cnt,
  input logic        tick,
  input logic [7:0]  ctrl,
  input logic [15:0] cmp_a,
  input logic        flag_ovf
);
  logic ld;
  assign ld = we_i && (addr_i == 3'd3);

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !ld && ctrl[6:5] == 2'b00) |=> (cnt == 16'($past(cnt) + 16'd1)));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !ld && ctrl[6:5] != 2'b11) |=> $stable(cnt));

  p_load_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> (cnt == $past(wdata_i)));

  p_period_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[6:5] == 2'b01 && cmp_a != 16'd0 && cnt < cmp_a && !we_i) |=> (cnt < cmp_a));

  p_wrap_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt == 16'hFFFF && !ld && ctrl[6:5] != 2'b11) |=> flag_ovf);

  p_stat_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd2) |-> (rdata_o[7:3] == 5'h1f));
endmodule

bind tmr16_channel tmr16_channel_chk chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .cnt     (cnt_q),
  .tick    (tick),
  .ctrl    (ctrl_q),
  .cmp_a   (cmp_a_q),
  .flag_ovf(flags_q.ovf)
);

// File: tb/tmr16_channel_tb_top.sv
`timescale 1ns/1ps
module tmr16_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  ext = '0;
  logic        sclr = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_a, irq_b, irq_v;
  int          checks = 0;
  int          errors = 0;
  logic [15:0] v;

  localparam logic [2:0] CTRL = 3'd0, IEN = 3'd1, STAT = 3'd2, CNT = 3'd3, CMPA = 3'd4, CMPB = 3'd5;

  always #2.5 clk = ~clk;

  tmr16_channel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ext_clk_i(ext), .sync_clr_i(sclr),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata),
    .irq_cmp_a_o(irq_a), .irq_cmp_b_o(irq_b), .irq_ovf_o(irq_v)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic prep(input logic [7:0] c, input logic [15:0] n);
    en = 1'b0;
    wr(CTRL, {8'h00, c});
    wr(CNT, n);
    wr(STAT, 16'h0000);
  endtask

  task automatic run(input int n);
    en = 1'b1;
    repeat (n) @(negedge clk);
    en = 1'b0;
  endtask

  task automatic run_cnt(input logic [7:0] c, input int n, input string tag, input logic [15:0] exp);
    prep(c, 16'h0000);
    run(n);
    rd(CNT, v); chk(tag, v, exp);
  endtask

  task automatic pulse_ext(input int lane);
    ext[lane] = 1'b1; repeat (3) @(negedge clk);
    ext[lane] = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic pulse_sync();
    sclr = 1'b1; repeat (3) @(negedge clk);
    sclr = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rd(CNT, v);  chk("R1 cnt", v, 16'h0000);
    rd(CMPA, v); chk("R1 cmpa", v, 16'hFFFF);
    rd(CMPB, v); chk("R1 cmpb", v, 16'hFFFF);
    rd(CTRL, v); chk("R1 ctrl", v, 16'h0000);
    rd(STAT, v); chk("R1 stat", v, 16'h00F8);
    rd(IEN, v);  chk("R1 ien", v, 16'h00F8);
    chk("R1 irqs", {13'd0, irq_a, irq_b, irq_v}, 16'h0000);
  endtask

  task automatic t_divisors();
    run_cnt(8'h00, 16, "R2 div1", 16'd16);
    run_cnt(8'h01, 16, "R2 div2", 16'd8);
    run_cnt(8'h02, 16, "R2 div4", 16'd4);
    run_cnt(8'h03, 16, "R2 div8", 16'd2);
    run_cnt(8'h02, 3,  "R2 div4 first edge", 16'd0);
    run_cnt(8'h02, 4,  "R2 div4 fourth edge", 16'd1);
  endtask

  task automatic t_edges();
    run_cnt(8'h0A, 2,  "R3 div4 half offset", 16'd1);
    run_cnt(8'h02, 2,  "R3 div4 phase0 two edges", 16'd0);
    run_cnt(8'h12, 16, "R3 div4 both edges", 16'd8);
    run_cnt(8'h0B, 4,  "R3 div8 half offset", 16'd1);
    run_cnt(8'h03, 4,  "R3 div8 phase0 four edges", 16'd0);
    run_cnt(8'h1B, 16, "R3 div8 both edges", 16'd4);
    run_cnt(8'h09, 1,  "R3 div2 edge bits ignored", 16'd0);
    run_cnt(8'h19, 16, "R3 div2 both bits ignored", 16'd8);
  endtask

  task automatic t_ext();
    prep(8'h05, 16'h0000);
    en = 1'b1;
    pulse_ext(1); pulse_ext(0); pulse_ext(1); pulse_ext(3); pulse_ext(1); pulse_ext(0);
    repeat (4) @(negedge clk);
    en = 1'b0;
    rd(CNT, v); chk("R4 ext pin1 only", v, 16'd3);
    pulse_ext(1); pulse_ext(1);
    repeat (4) @(negedge clk);
    rd(CNT, v); chk("R7 ext while disabled", v, 16'd3);
  endtask

  task automatic t_clear_cmp();
    prep(8'h20, 16'h0000);
    wr(CMPA, 16'd5); wr(CMPB, 16'hFFFF); wr(IEN, 16'h0000);
    run(5);
    rd(CNT, v);  chk("R5 cmpA fold to 0", v, 16'd0);
    rd(STAT, v); chk("R8 cmpA flag", v, 16'h00F9);
    chk("R10 irqA masked", {15'd0, irq_a}, 16'd0);
    run(7);
    rd(CNT, v);  chk("R5 cmpA period", v, 16'd2);
    wr(IEN, 16'h0001);
    rd(IEN, v);  chk("R10 ien readback", v, 16'h00F9);
    chk("R10 irqA on", {15'd0, irq_a}, 16'd1);
    chk("R10 irqB off", {15'd0, irq_b}, 16'd0);
    prep(8'h40, 16'h0000);
    wr(CMPA, 16'hFFFF); wr(CMPB, 16'd3);
    run(7);
    rd(CNT, v);  chk("R5 cmpB period", v, 16'd1);
    rd(STAT, v); chk("R8 cmpB flag", v, 16'h00FA);
    chk("R10 irqB masked", {15'd0, irq_b}, 16'd0);
    prep(8'h20, 16'h0000);
    wr(CMPA, 16'h0000);
    run(10);
    rd(CNT, v);  chk("R5 zero compare free-runs", v, 16'd10);
  endtask

  task automatic t_ovf();
    prep(8'h00, 16'hFFFE);
    wr(CMPA, 16'h0000); wr(CMPB, 16'h1234); wr(IEN, 16'h0000);
    run(1);
    rd(CNT, v);  chk("R8 reach FFFF", v, 16'hFFFF);
    rd(STAT, v); chk("R8 no flag yet", v, 16'h00F8);
    run(1);
    rd(CNT, v);  chk("R8 wrap", v, 16'h0000);
    rd(STAT, v); chk("R8 ovf and cmpA", v, 16'h00FD);
    wr(IEN, 16'h0004);
    chk("R10 irq ovf", {14'd0, irq_v, irq_a}, 16'd2);
    wr(STAT, 16'h00FE);
    rd(STAT, v); chk("R9 write0 clears only bit0", v, 16'h00FC);
    wr(STAT, 16'h00FB);
    rd(STAT, v); chk("R9 clear ovf", v, 16'h00F8);
    chk("R10 irq ovf drops", {15'd0, irq_v}, 16'd0);
  endtask

  task automatic t_sync();
    prep(8'h60, 16'h0100);
    pulse_sync();
    rd(CNT, v); chk("R6 sync clear while disabled", v, 16'h0000);
    prep(8'h00, 16'h0100);
    pulse_sync();
    rd(CNT, v); chk("R6 sync ignored in free mode", v, 16'h0100);
  endtask

  task automatic t_prio_map();
    prep(8'h00, 16'h0000);
    en = 1'b1;
    wr(CNT, 16'h0040);
    en = 1'b0;
    rd(CNT, v); chk("R7 write wins over tick", v, 16'h0040);
    run(0);
    rd(CNT, v); chk("R7 disabled holds", v, 16'h0040);
    wr(CTRL, 16'h009A);
    rd(CTRL, v); chk("R11 ctrl readback", v, 16'h009A);
    rd(3'd6, v); chk("R11 addr6 reads 0", v, 16'h0000);
    rd(3'd7, v); chk("R11 addr7 reads 0", v, 16'h0000);
    wr(CTRL, 16'h0000);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_divisors();
    t_edges();
    t_ext();
    t_clear_cmp();
    t_ovf();
    t_sync();
    t_prio_map();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule